// File: doc/BRIEF.md
# Control Register Mode-Flag Unit

This unit holds the paging and mode control words of a 32-bit x86-style core: the main control word (CR0), the page-table base (CR3), the feature-enable word (CR4), the long-mode bits of the extended feature word (EFER), and the state of the address-line-20 gate. The core writes these registers through one write port, which carries a select code and a data word. When a write lands, the unit works out its side effects. These are protected-mode tracking, entry to and exit from long mode, copies of the floating-point control bits, and feature gating. It keeps the result in a compact hidden-flags word that the rest of the pipeline decodes.

The outputs include the stored registers and the hidden flags. There is also an address mask that clears or passes bit 20. Three single-cycle pulses complete the outputs: a translation-cache flush, an exit request for the execution loop, and a request to truncate the instruction pointer to 32 bits. A small two-state machine sequences the unit. ST_BOOT is entered on reset and pushes the power-on CR0 value through the normal CR0 write path. It then takes the transition ST_BOOT→ST_RUN unconditionally. ST_RUN holds from then on and serves one write per cycle, plus the gate and code-segment inputs.

Top module: `cru_ctrl_unit`

## Requirements
- R1: After reset is released, the first clock in ST_BOOT loads CR0 through the write path with 0x60000010. After that edge, cr0_o = 0x60000010, the A20 mask is 0xFFFFFFFF, hflags_o = 0x02 and efer_o = 0. No flush is raised. Writes are served from the next cycle.
- R2: Every CR0 write (wr_sel = 0) stores the written value with bit 4 (ET) forced to 1.
- R3: A CR0 write that takes PG (bit 31) from 0 to 1 enters long mode only if EFER.LME (bit 8) and CR4.PAE (bit 5) are both set. Entry sets EFER.LMA (bit 10) and hidden-flag bit 5. In every other case LMA does not change.
- R4: A CR0 write that takes PG from 1 to 0 while LMA is set clears EFER.LMA, hidden bit 5 (LMA) and hidden bit 6 (CS64). It also pulses ip_trunc_o for one cycle.
- R5: Hidden bit 0 follows CR0.PE (bit 0). A CR0 write with PE = 0 sets hidden bit 1 (ADDSEG). A write with PE = 1 leaves ADDSEG unchanged.
- R6: CR0 bits 3:1 (MP, EM, TS) are copied to hidden bits 4:2 on each CR0 write.
- R7: tlb_flush_o pulses for one cycle after a write that changes any of the following: CR0 bits 31, 16 or 0; CR4 bits 7, 5 or 4. Writes that change only other bits raise no flush. Back-to-back flushing writes give one pulse each.
- R8: CR4 writes (wr_sel = 2) store bit 9 (OSFXSR) only when SSE_EN = 1; otherwise bit 9 is stored as 0. Hidden bit 7 follows the stored bit.
- R9: a20_mask_o = 0xFFEFFFFF with bit 20 set to the registered gate. A change of a20_gate pulses both tlb_flush_o and exit_req_o. The mask takes its new value on the same edge. A gate that holds its value raises nothing.
- R10: CR3 writes (wr_sel = 1) store the full word. They pulse tlb_flush_o only while CR0.PG is 1.
- R11: EFER writes (wr_sel = 3) change only bit 8 (LME). Bit 10 (LMA) keeps its value and all other bits read 0.
- R12: A cs64_we strobe loads hidden bit 6 with cs64_val, but only while long mode is active. Outside long mode the bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 CR0, 1 CR3, 2 CR4, 3 EFER |
| wdata | input | 32 | Write data |
| cs64_we | input | 1 | Load strobe for the 64-bit code-segment flag |
| cs64_val | input | 1 | Value for the code-segment flag |
| a20_gate | input | 1 | Address-line-20 gate level |
| cr0_o | output | 32 | Stored CR0 |
| cr3_o | output | 32 | Stored CR3 |
| cr4_o | output | 32 | Stored CR4 |
| efer_o | output | 32 | Stored EFER (bits 8 and 10 live) |
| hflags_o | output | 8 | Hidden flags: 0 PE, 1 ADDSEG, 4:2 MP/EM/TS, 5 LMA, 6 CS64, 7 OSFXSR |
| a20_mask_o | output | 32 | Physical address mask |
| tlb_flush_o | output | 1 | One-cycle translation flush request |
| exit_req_o | output | 1 | One-cycle execution-loop exit request |
| ip_trunc_o | output | 1 | One-cycle instruction-pointer truncate request |

## Verification
The bench sweeps all sixteen combinations of PE and the three floating-point bits, and all eight combinations of the three CR4 paging bits. A design that mirrored the wrong bit field, or that flushed on bits outside the watched set, fails these sweeps on a specific pattern. Long-mode entry is tried with and without PAE, and the exit is checked to clear CS64 and pulse the truncate request. A unit that ignored PAE, or left CS64 standing, would then show LMA or bit 6 at the wrong value. The A20 gate is toggled and then held, so a design that raised its exit request on every cycle rather than on a change would fail. Back-to-back writes and CR3 writes with paging off and then on catch pulses that were merged or mis-gated.

// File: rtl/cru_pkg.sv
package cru_pkg;
    localparam int XLEN = 32;

    localparam int CR0_PE = 0;
    localparam int CR0_MP = 1;
    localparam int CR0_FP_W = 3;
    localparam int CR0_ET = 4;
    localparam int CR0_WP = 16;
    localparam int CR0_PG = 31;

    localparam int CR4_PSE = 4;
    localparam int CR4_PAE = 5;
    localparam int CR4_PGE = 7;
    localparam int CR4_OSFX = 9;

    localparam int EFER_LME = 8;
    localparam int EFER_LMA = 10;

    localparam logic [XLEN-1:0] CR0_BOOT = 32'h6000_0010;

    typedef enum logic [1:0] {
        SEL_CR0  = 2'd0,
        SEL_CR3  = 2'd1,
        SEL_CR4  = 2'd2,
        SEL_EFER = 2'd3
    } cru_sel_e;

    typedef enum logic [0:0] {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } cru_state_e;

    typedef struct packed {
        logic                osfxsr;
        logic                cs64;
        logic                lma;
        logic [CR0_FP_W-1:0] fpu;
        logic                addseg;
        logic                pe;
    } cru_hflags_t;
endpackage

// File: rtl/cru_cr0_path.sv
module cru_cr0_path
    import cru_pkg::*;
(
    input  logic [XLEN-1:0] cur_cr0,
    input  logic [XLEN-1:0] new_cr0,
    input  logic            pae_en,
    input  logic            lme_en,
    input  logic            lma_cur,
    input  cru_hflags_t     cur_hf,
    output logic [XLEN-1:0] nxt_cr0,
    output logic            nxt_lma,
    output cru_hflags_t     nxt_hf,
    output logic            flush_req,
    output logic            ip_trunc
);
    localparam logic [XLEN-1:0] WATCH = (XLEN'(1) << CR0_PG) | (XLEN'(1) << CR0_WP) |
                                        (XLEN'(1) << CR0_PE);

    logic enter_lm;
    logic leave_lm;

    always_comb begin
        enter_lm  = !cur_cr0[CR0_PG] && new_cr0[CR0_PG] && lme_en && pae_en;
        leave_lm  = cur_cr0[CR0_PG] && !new_cr0[CR0_PG] && lma_cur;
        nxt_cr0   = new_cr0 | (XLEN'(1) << CR0_ET);
        flush_req = ((new_cr0 ^ cur_cr0) & WATCH) != '0;
        ip_trunc  = leave_lm;

        if (enter_lm)      nxt_lma = 1'b1;
        else if (leave_lm) nxt_lma = 1'b0;
        else               nxt_lma = lma_cur;

        nxt_hf     = cur_hf;
        nxt_hf.pe  = nxt_cr0[CR0_PE];
        nxt_hf.fpu = new_cr0[CR0_MP +: CR0_FP_W];
        nxt_hf.lma = nxt_lma;
        if (!nxt_cr0[CR0_PE]) nxt_hf.addseg = 1'b1;
        if (leave_lm)         nxt_hf.cs64   = 1'b0;
    end
endmodule

// File: rtl/cru_cr4_path.sv
module cru_cr4_path
    import cru_pkg::*;
#(
    parameter bit SSE_EN = 1'b1
) (
    input  logic [XLEN-1:0] cur_cr4,
    input  logic [XLEN-1:0] new_cr4,
    input  cru_hflags_t     cur_hf,
    output logic [XLEN-1:0] nxt_cr4,
    output cru_hflags_t     nxt_hf,
    output logic            flush_req
);
    localparam logic [XLEN-1:0] WATCH = (XLEN'(1) << CR4_PGE) | (XLEN'(1) << CR4_PAE) |
                                        (XLEN'(1) << CR4_PSE);

    logic [XLEN-1:0] gated;

    generate
        if (SSE_EN) begin : g_sse
            assign gated = new_cr4;
        end else begin : g_nosse
            assign gated = new_cr4 & ~(XLEN'(1) << CR4_OSFX);
        end
    endgenerate

    always_comb begin
        nxt_cr4       = gated;
        flush_req     = ((new_cr4 ^ cur_cr4) & WATCH) != '0;
        nxt_hf        = cur_hf;
        nxt_hf.osfxsr = gated[CR4_OSFX];
    end
endmodule

// File: rtl/cru_a20_gate.sv
module cru_a20_gate #(
    parameter int AW       = 32,
    parameter int GATE_BIT = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          gate_in,
    output logic          toggle,
    output logic [AW-1:0] mask
);
    logic gate_q;

    assign toggle = en && (gate_in != gate_q);
    assign mask   = ~(AW'(1) << GATE_BIT) | (AW'(gate_q) << GATE_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      gate_q <= 1'b1;
        else if (toggle) gate_q <= gate_in;
    end

    p_mask_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> mask[GATE_BIT] == $past(gate_in));
endmodule

// File: rtl/cru_ctrl_unit.sv
module cru_ctrl_unit
    import cru_pkg::*;
#(
    parameter bit SSE_EN   = 1'b1,
    parameter int A20_BIT  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wdata,
    input  logic        cs64_we,
    input  logic        cs64_val,
    input  logic        a20_gate,
    output logic [31:0] cr0_o,
    output logic [31:0] cr3_o,
    output logic [31:0] cr4_o,
    output logic [31:0] efer_o,
    output logic [7:0]  hflags_o,
    output logic [31:0] a20_mask_o,
    output logic        tlb_flush_o,
    output logic        exit_req_o,
    output logic        ip_trunc_o
);
    cru_state_e      state_q, state_n;
    logic [XLEN-1:0] cr0_q, cr3_q, cr4_q, efer_q;
    logic [XLEN-1:0] cr0_n, cr3_n, cr4_n, efer_n;
    cru_hflags_t     hf_q, hf_n;
    logic            flush_q, exit_q, trunc_q;
    logic            flush_n, exit_n, trunc_n;

    logic [XLEN-1:0] cr0_src;
    logic [XLEN-1:0] p0_cr0, p4_cr4;
    cru_hflags_t     p0_hf, p4_hf;
    logic            p0_lma, p0_flush, p0_trunc, p4_flush;
    logic            a20_toggle;

    assign cr0_src = (state_q == ST_BOOT) ? CR0_BOOT : wdata;

    cru_cr0_path u_cr0 (
        .cur_cr0   (cr0_q),
        .new_cr0   (cr0_src),
        .pae_en    (cr4_q[CR4_PAE]),
        .lme_en    (efer_q[EFER_LME]),
        .lma_cur   (efer_q[EFER_LMA]),
        .cur_hf    (hf_q),
        .nxt_cr0   (p0_cr0),
        .nxt_lma   (p0_lma),
        .nxt_hf    (p0_hf),
        .flush_req (p0_flush),
        .ip_trunc  (p0_trunc)
    );

    cru_cr4_path #(.SSE_EN(SSE_EN)) u_cr4 (
        .cur_cr4   (cr4_q),
        .new_cr4   (wdata),
        .cur_hf    (hf_q),
        .nxt_cr4   (p4_cr4),
        .nxt_hf    (p4_hf),
        .flush_req (p4_flush)
    );

    cru_a20_gate #(.AW(XLEN), .GATE_BIT(A20_BIT)) u_a20 (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state_q == ST_RUN),
        .gate_in(a20_gate),
        .toggle (a20_toggle),
        .mask   (a20_mask_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_n;
    end

    // next-state and register side effects
    always_comb begin
        state_n = state_q;
        cr0_n   = cr0_q;
        cr3_n   = cr3_q;
        cr4_n   = cr4_q;
        efer_n  = efer_q;
        hf_n    = hf_q;
        flush_n = 1'b0;
        exit_n  = 1'b0;
        trunc_n = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                cr0_n            = p0_cr0;
                efer_n[EFER_LMA] = p0_lma;
                hf_n             = p0_hf;
                state_n          = ST_RUN;
            end
            ST_RUN: begin
                if (wr_en) begin
                    unique case (cru_sel_e'(wr_sel))
                        SEL_CR0: begin
                            cr0_n            = p0_cr0;
                            efer_n[EFER_LMA] = p0_lma;
                            hf_n             = p0_hf;
                            flush_n          = p0_flush;
                            trunc_n          = p0_trunc;
                        end
                        SEL_CR3: begin
                            cr3_n   = wdata;
                            flush_n = cr0_q[CR0_PG];
                        end
                        SEL_CR4: begin
                            cr4_n   = p4_cr4;
                            hf_n    = p4_hf;
                            flush_n = p4_flush;
                        end
                        SEL_EFER: begin
                            efer_n           = '0;
                            efer_n[EFER_LME] = wdata[EFER_LME];
                            efer_n[EFER_LMA] = efer_q[EFER_LMA];
                        end
                    endcase
                end
                if (cs64_we) hf_n.cs64 = cs64_val & hf_n.lma;
                if (a20_toggle) begin
                    flush_n = 1'b1;
                    exit_n  = 1'b1;
                end
            end
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr0_q   <= '0;
            cr3_q   <= '0;
            cr4_q   <= '0;
            efer_q  <= '0;
            hf_q    <= '0;
            flush_q <= 1'b0;
            exit_q  <= 1'b0;
            trunc_q <= 1'b0;
        end else begin
            cr0_q   <= cr0_n;
            cr3_q   <= cr3_n;
            cr4_q   <= cr4_n;
            efer_q  <= efer_n;
            hf_q    <= hf_n;
            flush_q <= flush_n;
            exit_q  <= exit_n;
            trunc_q <= trunc_n;
        end
    end

    assign cr0_o       = cr0_q;
    assign cr3_o       = cr3_q;
    assign cr4_o       = cr4_q;
    assign efer_o      = efer_q;
    assign hflags_o    = hf_q;
    assign tlb_flush_o = flush_q;
    assign exit_req_o  = exit_q;
    assign ip_trunc_o  = trunc_q;

    p_et_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |-> cr0_q[CR0_ET]);
    p_lma_needs_pae_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(efer_q[EFER_LMA]) |-> cr4_q[CR4_PAE] && cr0_q[CR0_PG]);
    p_exit_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(efer_q[EFER_LMA]) |-> trunc_q && !hf_q.cs64 && !hf_q.lma);
    p_pe_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |-> hf_q.pe == cr0_q[CR0_PE]);
    p_addseg_real_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !cr0_q[CR0_PE]) |-> hf_q.addseg);
    p_osfx_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hf_q.osfxsr == cr4_q[CR4_OSFX]);
    p_a20_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a20_mask_o) |-> flush_q && exit_q);
    p_cs64_in_lm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hf_q.cs64 |-> hf_q.lma && efer_q[EFER_LMA]);
endmodule

// File: tb/sim_cru_ctrl_unit.sv
module sim_cru_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic        cs64_we = 1'b0;
    logic        cs64_val = 1'b0;
    logic        a20_gate = 1'b1;

    logic [31:0] cr0, cr3, cr4, efer, mask;
    logic [7:0]  hf;
    logic        flush, exitr, trunc;
    logic [31:0] n_cr0, n_cr3, n_cr4, n_efer, n_mask;
    logic [7:0]  n_hf;
    logic        n_flush, n_exit, n_trunc;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    cru_ctrl_unit #(.SSE_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wdata(wdata),
        .cs64_we(cs64_we), .cs64_val(cs64_val), .a20_gate(a20_gate),
        .cr0_o(cr0), .cr3_o(cr3), .cr4_o(cr4), .efer_o(efer), .hflags_o(hf),
        .a20_mask_o(mask), .tlb_flush_o(flush), .exit_req_o(exitr), .ip_trunc_o(trunc));

    cru_ctrl_unit #(.SSE_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wdata(wdata),
        .cs64_we(cs64_we), .cs64_val(cs64_val), .a20_gate(a20_gate),
        .cr0_o(n_cr0), .cr3_o(n_cr3), .cr4_o(n_cr4), .efer_o(n_efer), .hflags_o(n_hf),
        .a20_mask_o(n_mask), .tlb_flush_o(n_flush), .exit_req_o(n_exit), .ip_trunc_o(n_trunc));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cs64_load(input logic v);
        @(negedge clk);
        cs64_we = 1'b1; cs64_val = v;
        @(negedge clk);
        cs64_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic       prev_pe;
        logic [31:0] prev4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cr0 boot", cr0, 32'h6000_0010);
        chk("R1 a20 mask", mask, 32'hFFFF_FFFF);
        chk("R1 hflags", 32'(hf), 32'h02);
        chk("R1 efer", efer, 32'h0);
        chk("R1 no flush", 32'(flush), 32'h0);

        // R2 R5 R6 sweep over PE and MP/EM/TS
        prev_pe = 1'b0;
        for (int v = 0; v < 16; v++) begin
            wr(2'd0, 32'(v));
            chk("R2 cr0 ET forced", cr0, 32'(v) | 32'h10);
            chk("R5 R6 hflags", 32'(hf), (32'(v >> 1) << 2) | 32'h2 | 32'(v & 1));
            chk("R7 cr0 PE flush", 32'(flush), 32'(prev_pe != v[0]));
            prev_pe = v[0];
        end

        // R7 WP change flushes, CD-only change does not
        wr(2'd0, 32'h0001_001F);
        chk("R7 WP flush", 32'(flush), 32'h1);
        wr(2'd0, 32'h4001_001F);
        chk("R7 CD no flush", 32'(flush), 32'h0);

        // R7 back-to-back flushing writes
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wdata = 32'h0000_001F;
        @(negedge clk);
        chk("R7 b2b first", 32'(flush), 32'h1);
        wdata = 32'h0001_001F;
        @(negedge clk);
        chk("R7 b2b second", 32'(flush), 32'h1);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R7 pulse ends", 32'(flush), 32'h0);
        wr(2'd0, 32'h0);
        chk("R5 addseg hf", 32'(hf), 32'h02);

        // R7 CR4 paging bit sweep
        prev4 = 32'h0;
        for (int v = 0; v < 8; v++) begin
            logic [31:0] d;
            d = (32'(v & 1) << 4) | (32'((v >> 1) & 1) << 5) | (32'((v >> 2) & 1) << 7);
            wr(2'd2, d);
            chk("R7 cr4 value", cr4, d);
            chk("R7 cr4 flush", 32'(flush), 32'(d != prev4));
            prev4 = d;
        end
        wr(2'd2, prev4 | 32'h8);
        chk("R7 cr4 other bit no flush", 32'(flush), 32'h0);

        // R8 OSFXSR gating
        wr(2'd2, 32'h200);
        chk("R8 sse cr4", cr4, 32'h200);
        chk("R8 sse hf", 32'(hf), 32'h82);
        chk("R8 nosse cr4", n_cr4, 32'h0);
        chk("R8 nosse hf", 32'(n_hf), 32'h02);
        wr(2'd2, 32'h0);
        chk("R8 sse hf clear", 32'(hf), 32'h02);

        // R10 CR3 with paging off
        wr(2'd1, 32'h1234_5000);
        chk("R10 cr3 store", cr3, 32'h1234_5000);
        chk("R10 no flush pg0", 32'(flush), 32'h0);

        // R11 R3 long mode entry
        wr(2'd3, 32'hFFFF_FFFF);
        chk("R11 efer lme only", efer, 32'h100);
        wr(2'd2, 32'h20);
        chk("R7 pae flush", 32'(flush), 32'h1);
        wr(2'd0, 32'h8000_0001);
        chk("R3 cr0", cr0, 32'h8000_0011);
        chk("R3 efer lma", efer, 32'h500);
        chk("R3 hf lma", 32'(hf), 32'h23);
        chk("R3 flush", 32'(flush), 32'h1);
        cs64_load(1'b1);
        chk("R12 cs64 in lm", 32'(hf), 32'h63);
        wr(2'd1, 32'hABCD_0000);
        chk("R10 flush pg1", 32'(flush), 32'h1);
        wr(2'd3, 32'h0);
        chk("R11 lma kept", efer, 32'h400);

        // R4 long mode exit
        wr(2'd0, 32'h0000_0001);
        chk("R4 efer", efer, 32'h0);
        chk("R4 hf", 32'(hf), 32'h03);
        chk("R4 trunc", 32'(trunc), 32'h1);
        chk("R4 flush", 32'(flush), 32'h1);
        @(negedge clk);
        chk("R4 trunc ends", 32'(trunc), 32'h0);

        // R3 negative: LME without PAE
        wr(2'd3, 32'h100);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h8000_0001);
        chk("R3 no pae efer", efer, 32'h100);
        chk("R3 no pae hf", 32'(hf), 32'h03);
        cs64_load(1'b1);
        chk("R12 cs64 outside lm", 32'(hf), 32'h03);
        wr(2'd0, 32'h0000_0001);
        chk("R4 no trunc w/o lma", 32'(trunc), 32'h0);

        // R9 A20 gate
        @(negedge clk);
        a20_gate = 1'b0;
        @(negedge clk);
        chk("R9 mask low", mask, 32'hFFEF_FFFF);
        chk("R9 flush", 32'(flush), 32'h1);
        chk("R9 exit", 32'(exitr), 32'h1);
        @(negedge clk);
        chk("R9 hold no flush", 32'(flush), 32'h0);
        chk("R9 hold no exit", 32'(exitr), 32'h0);
        chk("R9 hold mask", mask, 32'hFFEF_FFFF);
        a20_gate = 1'b1;
        @(negedge clk);
        chk("R9 mask high", mask, 32'hFFFF_FFFF);
        chk("R9 exit again", 32'(exitr), 32'h1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule